// File: doc/BRIEF.md
# UART Prioritized Interrupt Identifier

This block is the interrupt enable and identification stage of one 16550-style UART channel. Five raw conditions come in from the channel's datapath: line errors, receive data ready (or trigger level reached), receive timeout, transmit holding register empty, and modem status change. Four enable bits gate these conditions. The block reports one pending source as a 4-bit identification code and drives a single interrupt request.

Line errors, transmit-empty and modem changes are event pulses. Each one is held in a sticky pending flag until software services it in the way that suits the source. Receive data ready and receive timeout are levels that the datapath owns, so the block samples them without storing them.

The identification code and the interrupt request are both registered. Each one shows the state that follows the clock edge at which the inputs were sampled.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted the code is 0001 and irq_o is 0. At the first clock edge after reset is released, if enable bit 1 is set and no higher source is pending, the code becomes 0010 and irq_o becomes 1, because the transmit-empty flag comes out of reset set.
- R2: Only the highest-priority enabled pending source is reported. The priority order and codes are: line status 0110, receive 0100/1100, transmit empty 0010, modem status 0000. The code 0001 means that nothing is pending.
- R3: Receive data and receive timeout share one priority level, and both are gated by enable bit 0. When that level is reported, the code is 1100 if the timeout input is high and 0100 otherwise.
- R4: The enable bits are: bit 0 receive, bit 1 transmit empty, bit 2 line status, bit 3 modem status. A disabled source is never reported and does not drive irq_o. Its pending flag keeps its state, so setting the enable bit later reports the source.
- R5: A line-error pulse sets the line-status flag. The flag holds through reads of the identification register and clears only on a line status register read. If a set and a clear arrive in the same cycle, the set wins.
- R6: A transmit-empty pulse sets the transmit flag. The flag clears on a holding register write. It also clears on an identification register read, but only when 0010 is the code being shown at that read; a read while another code is shown leaves the flag set.
- R7: A modem-change pulse sets the modem flag, and only a modem status register read clears it.
- R8: irq_o is 1 exactly when the code is not 0001. Both outputs change only at a clock edge, one register after the inputs are sampled.
- R9: A pending modem change stays hidden while any higher enabled source is pending. It appears once those sources have been serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_i | input | 4 | Source enables (bit0 receive, bit1 transmit empty, bit2 line status, bit3 modem) |
| line_err_i | input | 1 | Pulse: a line error was detected |
| rx_ready_i | input | 1 | Level: receive data available or trigger level reached |
| rx_timeout_i | input | 1 | Level: receive timeout pending |
| txe_set_i | input | 1 | Pulse: transmit holding register became empty |
| thr_wr_i | input | 1 | Pulse: transmit holding register written |
| iir_rd_i | input | 1 | Pulse: identification register read |
| lsr_rd_i | input | 1 | Pulse: line status register read |
| msr_rd_i | input | 1 | Pulse: modem status register read |
| msr_delta_i | input | 1 | Pulse: a modem input changed |
| iir_id_o | output | 4 | Identification code of the reported source |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters, so the transmit flag comes out of reset set. The block has only four enable bits and five source states. The bench therefore runs every enable value against every combination of pending sources, giving 512 cases. Each case is reached from a fresh reset in a single cycle of stimulus, and the bench compares the code and irq_o with an arithmetic model. Directed sequences then cover the service rules: set and clear in the same cycle, a read of the identification register while another code is shown, and modem changes becoming visible once higher sources are serviced.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ID_W = 4;
  localparam int EN_W = 4;

  // Enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef enum logic [ID_W-1:0] {
    IID_MODEM = 4'b0000,
    IID_NONE  = 4'b0001,
    IID_TXE   = 4'b0010,
    IID_RXD   = 4'b0100,
    IID_LINE  = 4'b0110,
    IID_RXTO  = 4'b1100
  } iid_e;

  typedef struct packed {
    logic line;
    logic rxd;
    logic rxto;
    logic txe;
    logic modem;
  } irq_src_t;

  // Highest-priority source wins; receive timeout refines the receive level.
  function automatic iid_e pick_iid(irq_src_t s);
    iid_e r;
    if (s.line)                r = IID_LINE;
    else if (s.rxto)           r = IID_RXTO;
    else if (s.rxd)            r = IID_RXD;
    else if (s.txe)            r = IID_TXE;
    else if (s.modem)          r = IID_MODEM;
    else                       r = IID_NONE;
    return r;
  endfunction

  function automatic logic any_src(irq_src_t s);
    return s.line | s.rxd | s.rxto | s.txe | s.modem;
  endfunction

endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o,
  output logic pend_nxt_o
);
  logic pend_q;

  // Set has priority over clear so no event is lost.
  always_comb begin
    if (set_i)      pend_nxt_o = 1'b1;
    else if (clr_i) pend_nxt_o = 1'b0;
    else            pend_nxt_o = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= RST_VAL;
    else        pend_q <= pend_nxt_o;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import uart_irq_pkg::*;
(
  input  logic [EN_W-1:0] ier_i,
  input  irq_src_t        raw_i,
  output irq_src_t        act_o
);
  always_comb begin
    act_o.line  = raw_i.line  & ier_i[EN_LINE];
    act_o.rxd   = raw_i.rxd   & ier_i[EN_RX];
    act_o.rxto  = raw_i.rxto  & ier_i[EN_RX];
    act_o.txe   = raw_i.txe   & ier_i[EN_TXE];
    act_o.modem = raw_i.modem & ier_i[EN_MODEM];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  irq_src_t act_i,
  output iid_e     iid_o,
  output logic     any_o
);
  assign iid_o = pick_iid(act_i);
  assign any_o = any_src(act_i);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter logic TXE_AT_RESET = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EN_W-1:0] ier_i,
  input  logic            line_err_i,
  input  logic            rx_ready_i,
  input  logic            rx_timeout_i,
  input  logic            txe_set_i,
  input  logic            thr_wr_i,
  input  logic            iir_rd_i,
  input  logic            lsr_rd_i,
  input  logic            msr_rd_i,
  input  logic            msr_delta_i,
  output logic [ID_W-1:0] iir_id_o,
  output logic            irq_o
);
  localparam int NSTK = 3;
  localparam int K_LINE = 0;
  localparam int K_TXE  = 1;
  localparam int K_MDM  = 2;
  localparam logic [NSTK-1:0] STK_RST = {1'b0, TXE_AT_RESET, 1'b0};

  iid_e id_q;
  logic irq_q;

  logic [NSTK-1:0] stk_set, stk_clr, stk_q, stk_nxt;

  // Named internal events for the checker
  logic line_pend, txe_pend, modem_pend;
  logic txe_iid_clr;

  assign txe_iid_clr = iir_rd_i && (id_q == IID_TXE);

  assign stk_set[K_LINE] = line_err_i;
  assign stk_clr[K_LINE] = lsr_rd_i;
  assign stk_set[K_TXE]  = txe_set_i;
  assign stk_clr[K_TXE]  = thr_wr_i | txe_iid_clr;
  assign stk_set[K_MDM]  = msr_delta_i;
  assign stk_clr[K_MDM]  = msr_rd_i;

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    irq_sticky #(.RST_VAL(STK_RST[g])) stk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (stk_set[g]),
      .clr_i      (stk_clr[g]),
      .pend_o     (stk_q[g]),
      .pend_nxt_o (stk_nxt[g])
    );
  end

  assign line_pend  = stk_q[K_LINE];
  assign txe_pend   = stk_q[K_TXE];
  assign modem_pend = stk_q[K_MDM];

  irq_src_t raw_nxt, act_nxt;
  iid_e     id_d;
  logic     any_d;

  always_comb begin
    raw_nxt.line  = stk_nxt[K_LINE];
    raw_nxt.rxd   = rx_ready_i;
    raw_nxt.rxto  = rx_timeout_i;
    raw_nxt.txe   = stk_nxt[K_TXE];
    raw_nxt.modem = stk_nxt[K_MDM];
  end

  irq_gate gate_i (
    .ier_i (ier_i),
    .raw_i (raw_nxt),
    .act_o (act_nxt)
  );

  irq_prio_enc enc_i (
    .act_i (act_nxt),
    .iid_o (id_d),
    .any_o (any_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= IID_NONE;
      irq_q <= 1'b0;
    end else begin
      id_q  <= id_d;
      irq_q <= any_d;
    end
  end

  assign iir_id_o = id_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier_i,
  input logic       iir_rd_i,
  input logic       txe_set_i,
  input logic       lsr_rd_i,
  input logic [3:0] iir_id_o,
  input logic       irq_o,
  input logic       line_pend,
  input logic       txe_pend,
  input logic       modem_pend
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  a_r8_irq_iff_id: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (iir_id_o != 4'b0001));

  a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (live && line_pend && $past(ier_i[2])) |-> iir_id_o == 4'b0110);

  a_r9_modem_last: assert property (@(posedge clk) disable iff (!rst_n)
    (live && iir_id_o == 4'b0000) |->
      (!(line_pend && $past(ier_i[2])) && !(txe_pend && $past(ier_i[1])) && modem_pend));

  a_r4_txe_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(ier_i[1])) |-> iir_id_o != 4'b0010);

  a_r6_iir_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_i && iir_id_o == 4'b0010 && !txe_set_i) |=> !txe_pend);

  a_r5_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pend && !lsr_rd_i) |=> line_pend);
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ier_i      (ier_i),
  .iir_rd_i   (iir_rd_i),
  .txe_set_i  (txe_set_i),
  .lsr_rd_i   (lsr_rd_i),
  .iir_id_o   (iir_id_o),
  .irq_o      (irq_o),
  .line_pend  (line_pend),
  .txe_pend   (txe_pend),
  .modem_pend (modem_pend)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ier = 4'h0;
  logic line_err = 0, rx_ready = 0, rx_to = 0, txe_set = 0, thr_wr = 0;
  logic iir_rd = 0, lsr_rd = 0, msr_rd = 0, msr_delta = 0;
  logic [3:0] id;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .line_err_i(line_err),
    .rx_ready_i(rx_ready), .rx_timeout_i(rx_to), .txe_set_i(txe_set),
    .thr_wr_i(thr_wr), .iir_rd_i(iir_rd), .lsr_rd_i(lsr_rd),
    .msr_rd_i(msr_rd), .msr_delta_i(msr_delta), .iir_id_o(id), .irq_o(irq)
  );

  // Independent model: lowest priority written first, higher ones overwrite.
  function automatic logic [3:0] model_id(logic [3:0] e, logic ls, logic rd,
                                          logic rt, logic th, logic ms);
    logic [3:0] c = 4'b0001;
    if (ms && e[3]) c = 4'b0000;
    if (th && e[1]) c = 4'b0010;
    if ((rd || rt) && e[0]) c = rt ? 4'b1100 : 4'b0100;
    if (ls && e[2]) c = 4'b0110;
    return c;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clr_pulses();
    line_err = 0; txe_set = 0; thr_wr = 0; iir_rd = 0;
    lsr_rd = 0; msr_rd = 0; msr_delta = 0;
  endtask

  // Inputs are set at a negedge; the next negedge shows the result.
  task automatic step();
    @(negedge clk);
    clr_pulses();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; clr_pulses(); rx_ready = 0; rx_to = 0;
    @(negedge clk);
  endtask

  task automatic chk_both(string tag, logic [3:0] exp);
    chk(tag, id, exp);
    chk({tag, " irq R8"}, {3'b0, irq}, {3'b0, exp != 4'b0001});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then transmit-empty reported at once
    ier = 4'b0010;
    @(negedge clk); @(negedge clk);
    chk("R1 reset id", id, 4'b0001);
    chk("R1 reset irq", {3'b0, irq}, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk_both("R1 txe after reset", 4'b0010);

    // R2 R3 R4 R8: every enable value against every source combination
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 32; p++) begin
        do_reset();
        rst_n = 1;
        ier = e[3:0];
        line_err = p[0]; rx_ready = p[1]; rx_to = p[2];
        thr_wr = !p[3]; msr_delta = p[4];
        step();
        chk_both("R2/R3/R4 sweep",
                 model_id(e[3:0], p[0], p[1], p[2], p[3], p[4]));
      end
    end

    // R5: line status holds through IIR read, clears on LSR read; set wins
    do_reset(); rst_n = 1; ier = 4'b0100;
    line_err = 1; step();
    chk_both("R5 set", 4'b0110);
    iir_rd = 1; step();
    chk_both("R5 iir read ignored", 4'b0110);
    line_err = 1; lsr_rd = 1; step();
    chk_both("R5 set wins", 4'b0110);
    lsr_rd = 1; step();
    chk_both("R5 lsr read clears", 4'b0001);

    // R6: transmit-empty clear rules
    do_reset(); rst_n = 1; ier = 4'b0010;
    step();
    chk_both("R6 pending", 4'b0010);
    iir_rd = 1; step();
    chk_both("R6 iir read clears", 4'b0001);
    txe_set = 1; step();
    chk_both("R6 set again", 4'b0010);
    thr_wr = 1; step();
    chk_both("R6 thr write clears", 4'b0001);
    txe_set = 1; ier = 4'b0110; line_err = 1; step();
    chk_both("R6 line above txe", 4'b0110);
    iir_rd = 1; step();
    chk_both("R6 read while line shown", 4'b0110);
    lsr_rd = 1; step();
    chk_both("R6 txe survived read", 4'b0010);

    // R7 R9: modem lowest, hidden until higher sources serviced
    do_reset(); rst_n = 1; ier = 4'b1111;
    thr_wr = 1; msr_delta = 1; line_err = 1; step();
    chk_both("R9 modem hidden by line", 4'b0110);
    lsr_rd = 1; step();
    chk_both("R9 modem appears", 4'b0000);
    txe_set = 1; step();
    chk_both("R9 modem hidden by txe", 4'b0010);
    thr_wr = 1; step();
    chk_both("R9 modem back", 4'b0000);
    iir_rd = 1; step();
    chk_both("R7 iir read ignored", 4'b0000);
    msr_rd = 1; step();
    chk_both("R7 msr read clears", 4'b0001);

    // R4: disabled source keeps its flag
    ier = 4'b0000; msr_delta = 1; step();
    chk_both("R4 masked modem", 4'b0001);
    ier = 4'b1000; step();
    chk_both("R4 enable reveals modem", 4'b0000);

    // R3: timeout vs data, rx level follows input
    ier = 4'b0001; rx_ready = 1; step();
    chk_both("R3 data", 4'b0100);
    rx_to = 1; step();
    chk_both("R3 timeout", 4'b1100);
    rx_ready = 0; rx_to = 0; ier = 4'b0000; step();
    chk_both("R3 released", 4'b0001);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule